// File: doc/BRIEF.md
# PHY polling access arbiter

The block shares one PHY management path between an autonomous polling engine and a host. While no host is active the engine runs with its enable bit set. When the host asks for access, the arbiter clears the enable bit. It waits until the engine's two-bit status shows that the engine has stopped, and only then grants the path to the host. Two conditions end the wait: the status, or a timeout counted in millisecond ticks.

When the host lets go, polling is not turned back on at once. A lazy re-enable timer starts instead. A host access that arrives before the timer runs out cancels it and is granted straight away, so a burst of host accesses keeps polling off throughout. When the timer expires, the arbiter sets the enable bit again and waits for the status to confirm that the engine is running.

The polling engine itself is modelled inside the block. It is a small state machine that follows the enable bit after a fixed number of cycles. A hold input freezes the engine so that a stuck engine can be produced on purpose.

Top module: `ppa_arbiter`

## Requirements
- R1: After reset, poll_en is 1, poll_status is 2'b11 (running), host_gnt is 0 and err is 0.
- R2: A host request that arrives while polling is active clears poll_en on the next cycle. host_gnt stays 0 for as long as poll_status reads 2'b11.
- R3: host_gnt rises once poll_status shows a stopped engine (any value other than 2'b11). It then stays high while host_req stays high and falls in the cycle after host_req drops.
- R4: A request that arrives while polling is already off and the re-enable timer is running cancels the timer. The grant follows one cycle later, and poll_en stays 0.
- R5: After a host release, poll_en stays 0 through REENABLE_MS-1 ms_tick pulses. It is set again right after the REENABLE_MS-th pulse.
- R6: When a re-enable expiry falls in the same cycle as a new host request, the request wins. The grant follows, and poll_en stays 0.
- R7: If the engine has not stopped within TIMEOUT_MS ticks of a disable, err pulses high for exactly one cycle, no grant is ever given, and poll_en returns to 1. The arbiter then waits for host_req to drop before it returns to the active state.
- R8: If the engine has not started within TIMEOUT_MS ticks of a re-enable, err pulses for one cycle and poll_en returns to 0. The re-enable timer then starts over and a later expiry retries.
- R9: The engine model's status becomes 2'b11 or 2'b00 ENG_DELAY cycles after poll_en differs from the engine's state. While poll_hold is high the status does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host wants the PHY management path, held for the whole access |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| poll_hold | input | 1 | Freezes the modelled polling engine |
| poll_en | output | 1 | Polling enable control bit |
| poll_status | output | 2 | Engine status, 2'b11 running, 2'b00 stopped |
| host_gnt | output | 1 | Host owns the management path |
| err | output | 1 | One-cycle pulse on a disable or enable timeout |

## Verification
On every cycle the assertions check three things. First, a grant only ever coexists with a stopped engine and a cleared enable bit. Second, err is a single-cycle pulse with no grant beside it, and the enable bit rises only on a tick. Third, the engine status moves only toward the enable value and freezes under hold. Several behaviours can only be shown by the bench's scenarios: that a burst of accesses keeps polling off, that a request wins a tie with the timer's expiry, that the enable bit waits the exact number of ticks before it is set again, and that a failed re-enable is retried. The bench's cycle model compares all four outputs on every clock.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

    typedef enum logic [2:0] {
        ARB_ACTIVE   = 3'd0,
        ARB_STOPPING = 3'd1,
        ARB_GRANTED  = 3'd2,
        ARB_IDLE_OFF = 3'd3,
        ARB_STARTING = 3'd4,
        ARB_BLOCKED  = 3'd5
    } arb_state_t;

    localparam logic [1:0] STAT_RUN  = 2'b11;
    localparam logic [1:0] STAT_HALT = 2'b00;

    typedef struct packed {
        logic en;
        logic gnt;
    } arb_ctrl_t;

    function automatic logic is_running(input logic [1:0] st);
        return st == STAT_RUN;
    endfunction

    function automatic arb_ctrl_t ctrl_of(input arb_state_t s);
        arb_ctrl_t c;
        c.en  = (s == ARB_ACTIVE) || (s == ARB_STARTING) || (s == ARB_BLOCKED);
        c.gnt = (s == ARB_GRANTED);
        return c;
    endfunction

endpackage

// File: rtl/ppa_poll_engine.sv
module ppa_poll_engine
    import ppa_pkg::*;
#(
    parameter int ENG_DELAY = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       hold,
    output logic [1:0] status
);
    localparam int CW = $clog2(ENG_DELAY + 1);

    logic          running;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b1;
            cnt     <= '0;
        end else if (en == running) begin
            cnt <= '0;
        end else if (!hold) begin
            if (cnt == CW'(ENG_DELAY - 1)) begin
                running <= en;
                cnt     <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign status = running ? STAT_RUN : STAT_HALT;

endmodule

// File: rtl/ppa_tick_timer.sv
module ppa_tick_timer #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expire = run && tick && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= expire ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ppa_arb_fsm.sv
module ppa_arb_fsm
    import ppa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       host_req,
    input  logic [1:0] status,
    input  logic       reen_expire,
    input  logic       tmo_expire,
    output arb_state_t state,
    output logic       poll_en,
    output logic       gnt,
    output logic       err
);
    arb_state_t nxt;
    logic       err_nxt;
    arb_ctrl_t  ctl;

    always_comb begin
        nxt     = state;
        err_nxt = 1'b0;
        unique case (state)
            ARB_ACTIVE:   if (host_req) nxt = ARB_STOPPING;
            ARB_STOPPING: begin
                if (!is_running(status)) begin
                    nxt = ARB_GRANTED;
                end else if (tmo_expire) begin
                    nxt     = ARB_BLOCKED;
                    err_nxt = 1'b1;
                end
            end
            ARB_GRANTED:  if (!host_req) nxt = ARB_IDLE_OFF;
            ARB_IDLE_OFF: begin
                if (host_req)         nxt = ARB_GRANTED;
                else if (reen_expire) nxt = ARB_STARTING;
            end
            ARB_STARTING: begin
                if (is_running(status)) begin
                    nxt = ARB_ACTIVE;
                end else if (tmo_expire) begin
                    nxt     = ARB_IDLE_OFF;
                    err_nxt = 1'b1;
                end
            end
            ARB_BLOCKED:  if (!host_req) nxt = ARB_ACTIVE;
            default:      nxt = ARB_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ARB_ACTIVE;
            err   <= 1'b0;
        end else begin
            state <= nxt;
            err   <= err_nxt;
        end
    end

    assign ctl     = ctrl_of(state);
    assign poll_en = ctl.en;
    assign gnt     = ctl.gnt;

endmodule

// File: rtl/ppa_arbiter.sv
module ppa_arbiter
    import ppa_pkg::*;
#(
    parameter int REENABLE_MS = 10,
    parameter int TIMEOUT_MS  = 1000,
    parameter int ENG_DELAY   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_req,
    input  logic       ms_tick,
    input  logic       poll_hold,
    output logic       poll_en,
    output logic [1:0] poll_status,
    output logic       host_gnt,
    output logic       err
);
    arb_state_t state;
    logic       reen_run, reen_exp;
    logic       tmo_run, tmo_exp;

    assign reen_run = (state == ARB_IDLE_OFF);
    assign tmo_run  = (state == ARB_STOPPING) || (state == ARB_STARTING);

    ppa_tick_timer #(.LIMIT(REENABLE_MS)) u_reen_timer (
        .clk(clk), .rst(rst), .run(reen_run), .tick(ms_tick), .expire(reen_exp)
    );

    ppa_tick_timer #(.LIMIT(TIMEOUT_MS)) u_tmo_timer (
        .clk(clk), .rst(rst), .run(tmo_run), .tick(ms_tick), .expire(tmo_exp)
    );

    ppa_arb_fsm u_fsm (
        .clk(clk), .rst(rst), .host_req(host_req), .status(poll_status),
        .reen_expire(reen_exp), .tmo_expire(tmo_exp), .state(state),
        .poll_en(poll_en), .gnt(host_gnt), .err(err)
    );

    ppa_poll_engine #(.ENG_DELAY(ENG_DELAY)) u_engine (
        .clk(clk), .rst(rst), .en(poll_en), .hold(poll_hold), .status(poll_status)
    );

endmodule

// File: rtl/ppa_arbiter_chk.sv
module ppa_arbiter_chk (
    input logic       clk,
    input logic       rst,
    input logic       host_req,
    input logic       ms_tick,
    input logic       poll_hold,
    input logic       poll_en,
    input logic [1:0] poll_status,
    input logic       host_gnt,
    input logic       err
);
    p_gnt_stopped_r3: assert property (@(posedge clk) disable iff (rst)
        host_gnt |-> (poll_status != 2'b11));

    p_gnt_no_en_r2: assert property (@(posedge clk) disable iff (rst)
        host_gnt |-> !poll_en);

    p_gnt_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (host_gnt && host_req) |=> host_gnt);

    p_err_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    p_err_no_gnt_r7: assert property (@(posedge clk) disable iff (rst)
        err |-> !host_gnt);

    p_en_rise_tick_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(poll_en) |-> $past(ms_tick));

    p_status_dir_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(poll_status) |-> ((poll_status == 2'b11) == $past(poll_en)));

    p_hold_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        poll_hold |=> $stable(poll_status));
endmodule

bind ppa_arbiter ppa_arbiter_chk u_chk (
    .clk(clk), .rst(rst), .host_req(host_req), .ms_tick(ms_tick),
    .poll_hold(poll_hold), .poll_en(poll_en), .poll_status(poll_status),
    .host_gnt(host_gnt), .err(err)
);

// File: tb/test_ppa_arbiter.sv
`timescale 1ns/1ps
module test_ppa_arbiter;
    localparam int RE = 10;
    localparam int TO = 1000;
    localparam int D  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_req = 1'b0, ms_tick = 1'b0, poll_hold = 1'b0;
    logic poll_en, host_gnt, err;
    logic [1:0] poll_status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ppa_arbiter #(.REENABLE_MS(RE), .TIMEOUT_MS(TO), .ENG_DELAY(D)) i_ppa_arbiter (
        .clk(clk), .rst(rst), .host_req(host_req), .ms_tick(ms_tick),
        .poll_hold(poll_hold), .poll_en(poll_en), .poll_status(poll_status),
        .host_gnt(host_gnt), .err(err)
    );

    // behavioural reference: mode 0 on,1 turning off,2 host,3 off-waiting,4 turning on,5 failed-off
    int m_mode, m_run, m_ecnt, m_rcnt, m_tcnt, m_err;

    function automatic int m_en(int mode);
        return (mode == 0 || mode == 4 || mode == 5) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_run = 1; m_ecnt = 0; m_rcnt = 0; m_tcnt = 0; m_err = 0;
        end else begin
            int en, nmode, rexp, texp;
            en = m_en(m_mode);
            rexp = (m_mode == 3 && ms_tick && m_rcnt == RE - 1) ? 1 : 0;
            texp = ((m_mode == 1 || m_mode == 4) && ms_tick && m_tcnt == TO - 1) ? 1 : 0;
            nmode = m_mode;
            m_err = 0;
            case (m_mode)
                0: if (host_req) nmode = 1;
                1: if (!m_run) nmode = 2; else if (texp) begin nmode = 5; m_err = 1; end
                2: if (!host_req) nmode = 3;
                3: if (host_req) nmode = 2; else if (rexp) nmode = 4;
                4: if (m_run) nmode = 0; else if (texp) begin nmode = 3; m_err = 1; end
                default: if (!host_req) nmode = 0;
            endcase
            if (m_mode != 3) m_rcnt = 0; else if (ms_tick) m_rcnt = rexp ? 0 : m_rcnt + 1;
            if (!(m_mode == 1 || m_mode == 4)) m_tcnt = 0;
            else if (ms_tick) m_tcnt = texp ? 0 : m_tcnt + 1;
            if (en == m_run) m_ecnt = 0;
            else if (!poll_hold) begin
                if (m_ecnt == D - 1) begin m_run = en; m_ecnt = 0; end
                else m_ecnt = m_ecnt + 1;
            end
            m_mode = nmode;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(poll_en == m_en(m_mode), "R5 model poll_en", poll_en, m_en(m_mode));
            chk(poll_status == (m_run ? 2'b11 : 2'b00), "R9 model poll_status",
                poll_status, m_run ? 3 : 0);
            chk(host_gnt == (m_mode == 2), "R3 model host_gnt", host_gnt, m_mode == 2);
            chk(err == m_err[0], "R7 model err", err, m_err);
        end
    end

    task automatic cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            cyc();
        end
        ms_tick = 1'b0;
    endtask

    task automatic wait_gnt(output bit got);
        got = 1'b0;
        for (int i = 0; i < 40 && !got; i++) begin
            cyc();
            got = host_gnt;
        end
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit got;
        bit en_seen;
        settle(3);
        rst = 1'b0;
        cyc();
        // R1 reset state
        chk(poll_en == 1'b1, "R1 poll_en", poll_en, 1);
        chk(poll_status == 2'b11, "R1 poll_status", poll_status, 3);
        chk(host_gnt == 1'b0 && err == 1'b0, "R1 gnt/err", host_gnt, 0);

        // R2/R3 single access
        host_req = 1'b1;
        cyc();
        chk(poll_en == 1'b0, "R2 enable cleared", poll_en, 0);
        chk(host_gnt == 1'b0, "R2 no grant while running", host_gnt, 0);
        wait_gnt(got);
        chk(got, "R3 grant given", got, 1);
        chk(poll_status == 2'b00, "R3 status stopped at grant", poll_status, 0);
        settle(3);
        chk(host_gnt == 1'b1, "R3 grant held", host_gnt, 1);
        host_req = 1'b0;
        cyc();
        chk(host_gnt == 1'b0, "R3 grant released", host_gnt, 0);
        // R5 lazy re-enable
        ticks(RE - 1);
        chk(poll_en == 1'b0, "R5 still off before expiry", poll_en, 0);
        ticks(1);
        chk(poll_en == 1'b1, "R5 re-enabled at expiry", poll_en, 1);
        settle(D + 3);
        chk(poll_status == 2'b11, "R9 engine running again", poll_status, 3);

        // R4 burst keeps polling off
        host_req = 1'b1;
        wait_gnt(got);
        host_req = 1'b0;
        cyc();
        ticks(5);
        en_seen = poll_en;
        host_req = 1'b1;
        cyc();
        chk(host_gnt == 1'b1, "R4 quick grant in burst", host_gnt, 1);
        chk(!en_seen && !poll_en, "R4 enable stayed clear", poll_en, 0);
        host_req = 1'b0;
        cyc();

        // R6 expiry coinciding with request
        ticks(RE - 1);
        host_req = 1'b1;
        ms_tick = 1'b1;
        cyc();
        ms_tick = 1'b0;
        chk(host_gnt == 1'b1, "R6 request wins tie", host_gnt, 1);
        chk(poll_en == 1'b0, "R6 enable stays clear", poll_en, 0);
        host_req = 1'b0;
        cyc();
        ticks(RE);
        settle(D + 3);
        chk(poll_status == 2'b11 && poll_en, "R5 running after tie", poll_status, 3);

        // R7 disable timeout
        poll_hold = 1'b1;
        host_req = 1'b1;
        settle(3);
        chk(poll_en == 1'b0 && host_gnt == 1'b0, "R2 waiting on stuck engine", host_gnt, 0);
        got = 1'b0;
        for (int i = 0; i < TO - 1; i++) begin
            ms_tick = 1'b1;
            cyc();
            if (err || host_gnt) got = 1'b1;
        end
        chk(!got, "R7 no err or grant before timeout", got, 0);
        ticks(1);
        chk(err == 1'b1, "R7 err pulse", err, 1);
        chk(host_gnt == 1'b0, "R7 no grant", host_gnt, 0);
        chk(poll_en == 1'b1, "R7 enable restored", poll_en, 1);
        cyc();
        chk(err == 1'b0, "R7 err single cycle", err, 0);
        settle(3);
        chk(host_gnt == 1'b0, "R7 blocked while request held", host_gnt, 0);
        host_req = 1'b0;
        poll_hold = 1'b0;
        settle(D + 3);
        chk(poll_en == 1'b1 && poll_status == 2'b11, "R7 back to active", poll_en, 1);

        // R8 enable timeout and retry
        host_req = 1'b1;
        wait_gnt(got);
        host_req = 1'b0;
        cyc();
        poll_hold = 1'b1;
        ticks(RE);
        chk(poll_en == 1'b1, "R8 re-enable attempted", poll_en, 1);
        ticks(TO);
        chk(err == 1'b1, "R8 err pulse", err, 1);
        chk(poll_en == 1'b0, "R8 enable cleared again", poll_en, 0);
        chk(poll_status == 2'b00, "R9 hold froze engine", poll_status, 0);
        poll_hold = 1'b0;
        cyc();
        ticks(RE - 1);
        chk(poll_en == 1'b0, "R8 timer restarted", poll_en, 0);
        ticks(1);
        settle(D + 3);
        chk(poll_en == 1'b1 && poll_status == 2'b11, "R8 retry succeeds", poll_status, 3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule